// File: doc/BRIEF.md
# Flash Block Erase Controller

This controller erases one fixed-size block of on-chip program memory on request from the CPU. Software sets a 22-bit table pointer through three byte registers. It then writes a two-byte unlock key and sets a start bit in the control register. The start write must also carry the write-enable and erase-select flags. When all of these are in place, the controller stalls the CPU and sends a one-cycle erase command to the memory array. The command carries the block index, which is the upper twelve pointer bits. The controller then counts a parameterised erase time.

A block is 1024 bytes (512 16-bit words). The lower ten pointer bits play no part in an erase. The erase ends only when the internal timer expires. At that point the stall drops, the start bit clears and a completion flag is raised for software to poll and clear. The unlock is used up by the next register write, so every erase needs a fresh key pair.

Register map (3-bit address): 0 = pointer bits 7:0, 1 = pointer bits 15:8, 2 = pointer bits 21:16 (in data bits 5:0), 3 = control, 4 = key. Control bits: 1 = start (reads as busy), 2 = write enable, 3 = completion flag, 4 = erase select. All other bits read 0.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset all register reads return 0, and `cpu_stall` and `ers_cmd` are low.
- R2: Pointer bytes at addresses 0, 1 and 2 read back what was written. Data bits 7:6 at address 2 are dropped and read as 0.
- R3: A control write with bits 1, 2 and 4 all set, made right after the key writes 55h then AAh, starts an erase. In the next cycle `cpu_stall` is high and `ers_cmd` is high for exactly one cycle. `ers_blk` equals pointer bits 21:10, and pointer bits 9:0 have no effect on it.
- R4: `cpu_stall` stays high for exactly ERASE_CYCLES cycles and then falls by itself. Control bit 1 reads 1 during the erase and 0 after it.
- R5: A start write with bit 2 or bit 4 clear does not start an erase: the stall stays low and bit 1 reads 0.
- R6: Without a completed unlock, no erase starts. This covers a missing key, a wrong second byte, the keys in reverse order, and any other register write between the two key bytes.
- R7: An unlock is used up by the next register write of any kind. A start attempt after a finished erase, or after any other write that follows the unlock, is ignored unless a new key pair is written first.
- R8: Control bit 3 becomes 1 when an erase finishes. A control write with bit 3 at 0 clears it, and writing 1 to it never sets it.
- R9: Register writes made while `cpu_stall` is high change no register.
- R10: Control bits 2 and 4 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (write and read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cpu_stall | output | 1 | Holds the CPU while an erase runs |
| ers_cmd | output | 1 | One-cycle erase command to the array |
| ers_blk | output | 12 | Block index sent with the erase command |

## Verification
The erase path is driven with random pointers and a random choice among five request shapes:
- a proper request;
- a request missing write enable;
- a request missing erase select;
- a wrong second key byte;
- a stray write between the key bytes.

Only the proper shape may stall the CPU, so these runs separate the key state from the flag gating. Directed cases add the following:
- reversed key order;
- re-use of a spent unlock;
- writes during the stall;
- the completion flag's write-0 and write-1 behaviour;
- a pointer whose low ten bits are all ones, which shows that the block index ignores them.

Counting the stall cycles and the single command pulse ties each start to the timer length.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PTR0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_PTR1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_PTR2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd4;

  localparam int unsigned B_GO   = 1;
  localparam int unsigned B_WEN  = 2;
  localparam int unsigned B_DONE = 3;
  localparam int unsigned B_ESEL = 4;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_FIRST = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/fec_unlock.sv
module fec_unlock
  import fec_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              armed
);
  unlock_e st_q, st_d;
  logic    key_wr;

  assign key_wr = wr_en && (wr_addr == A_KEY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      UL_IDLE: begin
        if (key_wr && (wr_data == KEY_A)) st_d = UL_FIRST;
      end
      UL_FIRST: begin
        if (wr_en) begin
          if (key_wr && (wr_data == KEY_B)) st_d = UL_ARMED;
          else                              st_d = UL_IDLE;
        end
      end
      UL_ARMED: begin
        if (wr_en) st_d = UL_IDLE;
      end
      default: st_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  AST_ARM_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(st_q) == UL_FIRST)); // R6

  AST_ARM_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en) |=> !armed); // R7
endmodule

// File: rtl/fec_regs.sv
module fec_regs
  import fec_pkg::*;
#(
  parameter int unsigned PTR_W   = 22,
  parameter int unsigned BLK_LSB = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     armed,
  input  logic                     busy,
  input  logic                     done_evt,
  output logic                     start_req,
  output logic [PTR_W-BLK_LSB-1:0] blk,
  output logic [7:0]               rdata
);
  localparam int unsigned NB = (PTR_W + 7) / 8;
  localparam int unsigned PW = NB * 8;

  logic [PW-1:0] ptr_pad;
  logic          ctrl_wr;
  logic          wen_q, esel_q, done_q;
  logic          done_d;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int unsigned LW = ((PTR_W - g * 8) >= 8) ? 8 : (PTR_W - g * 8);
    localparam logic [7:0]  LMASK = 8'((1 << LW) - 1);
    logic [7:0] lane_q;
    logic       lane_we;
    assign lane_we = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_we) lane_q <= wr_data & LMASK;
    end
    assign ptr_pad[g*8 +: 8] = lane_q;
  end

  assign blk = ptr_pad[PTR_W-1:BLK_LSB];

  assign start_req = ctrl_wr && armed && wr_data[B_GO]
                  && wr_data[B_WEN] && wr_data[B_ESEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      esel_q <= 1'b0;
    end else if (ctrl_wr) begin
      wen_q  <= wr_data[B_WEN];
      esel_q <= wr_data[B_ESEL];
    end
  end

  always_comb begin
    done_d = done_q;
    if (done_evt)                        done_d = 1'b1;
    else if (ctrl_wr && !wr_data[B_DONE]) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == A_CTRL) begin
      rdata[B_GO]   = busy;
      rdata[B_WEN]  = wen_q;
      rdata[B_DONE] = done_q;
      rdata[B_ESEL] = esel_q;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (rd_addr == ADDR_W'(i)) rdata = ptr_pad[i*8 +: 8];
      end
    end
  end

  AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr_pad)); // R9

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_q); // R8

  AST_DONE_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !done_evt) |=> !done_q); // R8
endmodule

// File: rtl/fec_timer.sv
module fec_timer #(
  parameter int unsigned CYCLES = 1000,
  parameter int unsigned BLK_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_in,
  output logic             busy,
  output logic             cmd,
  output logic [BLK_W-1:0] blk_out,
  output logic             done_evt
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_d, cmd_d;
  logic             blk_en;

  assign done_evt = busy && (cnt_q == '0);
  assign blk_en   = start && !busy;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    cmd_d  = 1'b0;
    if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      cmd_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      cmd   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      cmd   <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_out <= '0;
    else if (blk_en) blk_out <= blk_in;
  end

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> !cmd); // R3

  AST_CMD_WITH_STALL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LOAD)); // R4

  AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt_q != '0)) |=> (busy && (cnt_q == $past(cnt_q) - 1'b1))); // R4
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int unsigned PTR_W        = 22,
  parameter int unsigned BLK_LSB      = 10,
  parameter int unsigned ERASE_CYCLES = 1000,
  parameter logic [7:0]  KEY_A        = 8'h55,
  parameter logic [7:0]  KEY_B        = 8'hAA
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  output logic                     cpu_stall,
  output logic                     ers_cmd,
  output logic [PTR_W-BLK_LSB-1:0] ers_blk
);
  localparam int unsigned BLK_W = PTR_W - BLK_LSB;

  logic             wr_en;
  logic             armed;
  logic             start_req;
  logic             busy;
  logic             done_evt;
  logic [BLK_W-1:0] blk;

  assign wr_en = reg_wr && !busy;

  fec_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .armed   (armed)
  );

  fec_regs #(.PTR_W(PTR_W), .BLK_LSB(BLK_LSB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (reg_addr),
    .wr_data   (reg_wdata),
    .rd_addr   (reg_addr),
    .armed     (armed),
    .busy      (busy),
    .done_evt  (done_evt),
    .start_req (start_req),
    .blk       (blk),
    .rdata     (reg_rdata)
  );

  fec_timer #(.CYCLES(ERASE_CYCLES), .BLK_W(BLK_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_req),
    .blk_in   (blk),
    .busy     (busy),
    .cmd      (ers_cmd),
    .blk_out  (ers_blk),
    .done_evt (done_evt)
  );

  assign cpu_stall = busy;

  AST_STALL_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(armed)); // R6

  AST_STALL_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> ($past(reg_wdata[B_WEN]) && $past(reg_wdata[B_ESEL]))); // R5

  AST_BLK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && !ers_cmd) |-> $stable(ers_blk)); // R3
endmodule

// File: tb/sim_flash_erase_ctrl.sv
module sim_flash_erase_ctrl;
  localparam int N = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        cpu_stall;
  logic        ers_cmd;
  logic [11:0] ers_blk;

  int checks = 0;
  int errors = 0;

  logic [21:0] ptr_m;
  logic        wen_m, esel_m, done_m;

  flash_erase_ctrl #(.ERASE_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
    .ers_cmd(ers_cmd), .ers_blk(ers_blk)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] ctrl_exp(logic w, logic e, logic d, logic go);
    return {3'b000, e, d, w, go, 1'b0};
  endfunction

  function automatic logic [11:0] blk_of(logic [21:0] p);
    return p[21:10];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_ptr(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    wr(3'd0, b0); wr(3'd1, b1); wr(3'd2, b2);
    ptr_m = {b2[5:0], b1, b0};
  endtask

  task automatic unlock();
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA);
  endtask

  task automatic ctrl_wr(logic w, logic e, logic go, logic dbit);
    wr(3'd3, {3'b000, e, dbit, w, go, 1'b0});
    wen_m = w; esel_m = e;
    if (!dbit) done_m = 1'b0;
  endtask

  task automatic expect_erase(string tag);
    logic [7:0] r;
    int n;
    check({tag, " R3 stall rises"}, 32'(cpu_stall), 32'd1);
    check({tag, " R3 cmd pulse"}, 32'(ers_cmd), 32'd1);
    check({tag, " R3 block index"}, 32'(ers_blk), 32'(blk_of(ptr_m)));
    rd(3'd3, r);
    check({tag, " R4 go reads 1"}, 32'(r), 32'(ctrl_exp(wen_m, esel_m, done_m, 1'b1)));
    n = 0;
    while (cpu_stall && n < 4 * N) begin
      n++;
      @(negedge clk);
      if (n == 1) check({tag, " R3 cmd single cycle"}, 32'(ers_cmd), 32'd0);
    end
    check({tag, " R4 stall length"}, 32'(n), 32'(N));
    done_m = 1'b1;
    rd(3'd3, r);
    check({tag, " R8 done set, R4 go clear"}, 32'(r), 32'(ctrl_exp(wen_m, esel_m, 1'b1, 1'b0)));
  endtask

  task automatic expect_none(string tag);
    logic [7:0] r;
    check({tag, " no stall"}, 32'(cpu_stall), 32'd0);
    check({tag, " no cmd"}, 32'(ers_cmd), 32'd0);
    rd(3'd3, r);
    check({tag, " R10 ctrl readback"}, 32'(r), 32'(ctrl_exp(wen_m, esel_m, done_m, 1'b0)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed1234));
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    rst_n = 1'b0;
    ptr_m = '0; wen_m = 0; esel_m = 0; done_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 stall", 32'(cpu_stall), 32'd0);
    check("R1 cmd", 32'(ers_cmd), 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R1 register zero", 32'(r), 32'd0);
    end

    // R2 readback with masked upper bits
    set_ptr(8'hA5, 8'h3C, 8'hFF);
    rd(3'd0, r); check("R2 byte0", 32'(r), 32'h0A5);
    rd(3'd1, r); check("R2 byte1", 32'(r), 32'h03C);
    rd(3'd2, r); check("R2 byte2 masked", 32'(r), 32'h03F);

    // R3 low ten bits ignored: pointer 0x0003FF gives block 0
    set_ptr(8'hFF, 8'h03, 8'h00);
    unlock(); ctrl_wr(1, 1, 1, 0);
    expect_erase("low bits");

    // R7 spent unlock
    ctrl_wr(1, 1, 1, 1);
    expect_none("R7 reuse after erase");

    // R7 armed then other write
    unlock(); wr(3'd0, ptr_m[7:0]); ctrl_wr(1, 1, 1, 1);
    expect_none("R7 arm dropped by write");

    // R6 reversed keys
    wr(3'd4, 8'hAA); wr(3'd4, 8'h55); ctrl_wr(1, 1, 1, 1);
    expect_none("R6 reversed keys");

    // R9 writes during erase, R8 done flag semantics
    set_ptr(8'h12, 8'hF4, 8'h2B);
    unlock(); ctrl_wr(1, 1, 1, 0);
    check("R9 stall up", 32'(cpu_stall), 32'd1);
    wr(3'd0, 8'hEE);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h55);
    while (cpu_stall) @(negedge clk);
    done_m = 1'b1;
    rd(3'd0, r); check("R9 ptr unchanged", 32'(r), 32'h012);
    rd(3'd3, r); check("R9 ctrl unchanged", 32'(r), 32'(ctrl_exp(1, 1, 1, 0)));
    wr(3'd4, 8'hAA); ctrl_wr(1, 1, 1, 1);
    expect_none("R9 key during erase ignored");
    ctrl_wr(1, 1, 0, 1);
    rd(3'd3, r); check("R8 write 1 keeps flag", 32'(r), 32'(ctrl_exp(1, 1, 1, 0)));
    ctrl_wr(1, 1, 0, 0);
    rd(3'd3, r); check("R8 write 0 clears", 32'(r), 32'(ctrl_exp(1, 1, 0, 0)));
    ctrl_wr(1, 1, 0, 1);
    rd(3'd3, r); check("R8 write 1 no set", 32'(r), 32'(ctrl_exp(1, 1, 0, 0)));

    // Random mix of request shapes
    for (int it = 0; it < 24; it++) begin
      logic [7:0] b0, b1, b2, bad;
      int sc;
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      set_ptr(b0, b1, b2);
      rd(3'd1, r); check("R2 random byte1", 32'(r), 32'(b1));
      rd(3'd2, r); check("R2 random byte2", 32'(r), 32'({2'b00, b2[5:0]}));
      sc = int'($urandom % 5);
      case (sc)
        3: begin
          bad = 8'($urandom);
          if (bad == 8'hAA) bad = 8'h00;
          wr(3'd4, 8'h55); wr(3'd4, bad);
        end
        4: begin
          wr(3'd4, 8'h55); wr(3'd0, b0); wr(3'd4, 8'hAA);
        end
        default: unlock();
      endcase
      ctrl_wr(sc != 1, sc != 2, 1'b1, 1'b0);
      if (sc == 0) expect_erase("random R3");
      else if (sc < 3) expect_none("random R5 flags");
      else expect_none("random R6 key");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule